// File: doc/BRIEF.md
# LCD Power-Mode Sequencer

This block sits between a display controller's timing generator and the panel pins. It chooses among three operating modes (normal, doze and power-save) and masks the panel signals to match the mode in force. A 2-bit mode select is decoded each clock. Entering and leaving power-save are not instant. The panel power pin and the panel signal group are switched in a fixed order, and the power step is timed in frame periods taken from a frame-boundary pulse.

In automatic operation, software writes the mode and waits until `busy` falls. It can also follow the vertical non-display flag to count frames while a transition is pending. When manual power control is enabled, the frame wait is skipped. The panel power pin then follows a software-driven level, so power can be sequenced at any chosen moment. The block also reports two things: whether look-up table access is allowed, and whether the display sequencer is running. All pins are plain level signals. No data path here carries a handshake, so no pin has back-pressure.

Top module: `lcd_pwr_seq`

## Requirements
- R1: The mode select is decoded as 00 = power-save, 10 = doze and 11 = normal. A new code sets the gating of the panel outputs one clock after it is applied.
- R2: Code 01 is reserved. While it is applied, the mode in force and every output stay as they were.
- R3: A power-save request made in a running mode starts a power-down. Panel power and the panel signals stay active, and `busy` is high, until the second `frame_tick` after the request is sampled. On that edge all panel outputs and panel power go low and `busy` clears. A tick sampled in the same cycle as the request is not counted.
- R4: Leaving power-save enables the panel signals, `lut_ok` and `seq_run` one clock after the request, with `busy` high. Panel power rises, and `busy` clears, on the second following `frame_tick`.
- R5: Once settled in power-save, every panel output is 0, including `pnl_pwr` and `vnd_flag`. `lut_ok` and `seq_run` are 0.
- R6: In doze, `pnl_data` and `pnl_shift` are 0. Line, frame, ready, `vnd_flag` and panel power stay active. `lut_ok` and `seq_run` are 1.
- R7: In normal mode every panel output equals its source input.
- R8: Reversing a request while its transition is pending returns the block to the mode it was leaving on the next clock. Panel power does not change.
- R9: With `man_pwr_en` high, transitions complete one clock after the request with no frame wait, and `pnl_pwr` equals `man_pwr_on` in every mode.
- R10: `vnd_flag` equals `vblank_in` while the sequencer runs and is 0 otherwise.
- R11: After reset the block is in power-save. All outputs are 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Requested operating mode |
| man_pwr_en | input | 1 | Manual panel-power control enable |
| man_pwr_on | input | 1 | Panel power level used in manual control |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| vblank_in | input | 1 | Vertical non-display indicator from the timing generator |
| src_data | input | DATA_W | Pixel data from the controller |
| src_shift | input | 1 | Pixel shift clock from the controller |
| src_line | input | 1 | Line pulse from the controller |
| src_frame | input | 1 | Frame pulse from the controller |
| src_ready | input | 1 | Data-ready from the controller |
| pnl_data | output | DATA_W | Gated pixel data to the panel |
| pnl_shift | output | 1 | Gated shift clock |
| pnl_line | output | 1 | Gated line pulse |
| pnl_frame | output | 1 | Gated frame pulse |
| pnl_ready | output | 1 | Gated data-ready |
| pnl_pwr | output | 1 | Panel power enable |
| vnd_flag | output | 1 | Non-display status for frame counting |
| lut_ok | output | 1 | Look-up table access permitted |
| seq_run | output | 1 | Display sequencer running |
| busy | output | 1 | Power transition pending |

## Verification
At every settled mode and at every intermediate transition point, the gated outputs are swept over 64 source patterns. The patterns vary the data value, each control bit and the non-display input independently, so a mask applied to the wrong signal group shows up as a mismatch on specific bits. Frame pulses are applied one at a time, including one in the same cycle as the request. This separates a one-tick from a two-tick wait. Reversed requests and the reserved code show whether pending state is cleared or kept, and manual mode shows that power follows the software level rather than the frame count.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_UP   = 2'd1,
    ST_ON   = 2'd2,
    ST_DOWN = 2'd3
  } lpm_state_e;

  localparam logic [1:0] MODE_SAVE = 2'b00;
  localparam logic [1:0] MODE_RSVD = 2'b01;
  localparam logic [1:0] MODE_DOZE = 2'b10;
  localparam logic [1:0] MODE_NORM = 2'b11;
endpackage

// File: rtl/lpm_mode_decode.sv
module lpm_mode_decode
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  output logic       want_off,
  output logic       doze_q
);
  logic want_off_q;

  // reserved code keeps the last accepted target
  always_comb begin
    if (mode_sel == MODE_RSVD) want_off = want_off_q;
    else                       want_off = (mode_sel == MODE_SAVE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want_off_q <= 1'b1;
      doze_q     <= 1'b0;
    end else begin
      want_off_q <= want_off;
      if (mode_sel == MODE_DOZE)      doze_q <= 1'b1;
      else if (mode_sel == MODE_NORM) doze_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lpm_frame_timer.sv
module lpm_frame_timer #(
  parameter int unsigned DELAY_FRAMES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int unsigned NEED = DELAY_FRAMES + 1;
  localparam int unsigned CW   = $clog2(NEED + 1);

  logic [CW-1:0] cnt;

  assign done = run && tick && (cnt == CW'(NEED - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (done)  cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lpm_power_fsm.sv
module lpm_power_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       want_off,
  input  logic       man_en,
  input  logic       done,
  output lpm_state_e state,
  output logic       timer_run
);
  lpm_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OFF:  if (!want_off) nxt = man_en ? ST_ON : ST_UP;
      ST_UP: begin
        if (want_off)             nxt = ST_OFF;
        else if (man_en || done)  nxt = ST_ON;
      end
      ST_ON:   if (want_off) nxt = man_en ? ST_OFF : ST_DOWN;
      ST_DOWN: begin
        if (!want_off)            nxt = ST_ON;
        else if (man_en || done)  nxt = ST_OFF;
      end
      default: nxt = ST_OFF;
    endcase
  end

  assign timer_run = ((state == ST_UP) && !want_off) ||
                     ((state == ST_DOWN) && want_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= nxt;
  end
endmodule

// File: rtl/lpm_out_gate.sv
module lpm_out_gate
  import lpm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  lpm_state_e        state,
  input  logic              doze_q,
  input  logic              man_en,
  input  logic              man_on,
  input  logic              vblank_in,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_shift,
  input  logic              src_line,
  input  logic              src_frame,
  input  logic              src_ready,
  output logic [DATA_W-1:0] pnl_data,
  output logic              pnl_shift,
  output logic              pnl_line,
  output logic              pnl_frame,
  output logic              pnl_ready,
  output logic              pnl_pwr,
  output logic              vnd_flag,
  output logic              lut_ok,
  output logic              seq_run,
  output logic              busy
);
  logic sig_en;
  logic pix_en;

  assign sig_en    = (state != ST_OFF);
  assign pix_en    = sig_en && !doze_q;
  assign pnl_data  = pix_en ? src_data : '0;
  assign pnl_shift = pix_en && src_shift;
  assign pnl_line  = sig_en && src_line;
  assign pnl_frame = sig_en && src_frame;
  assign pnl_ready = sig_en && src_ready;
  assign vnd_flag  = sig_en && vblank_in;
  assign lut_ok    = sig_en;
  assign seq_run   = sig_en;
  assign busy      = (state == ST_UP) || (state == ST_DOWN);
  assign pnl_pwr   = man_en ? man_on : ((state == ST_ON) || (state == ST_DOWN));
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lpm_pkg::*;
#(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned DELAY_FRAMES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              man_pwr_en,
  input  logic              man_pwr_on,
  input  logic              frame_tick,
  input  logic              vblank_in,
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_shift,
  input  logic              src_line,
  input  logic              src_frame,
  input  logic              src_ready,
  output logic [DATA_W-1:0] pnl_data,
  output logic              pnl_shift,
  output logic              pnl_line,
  output logic              pnl_frame,
  output logic              pnl_ready,
  output logic              pnl_pwr,
  output logic              vnd_flag,
  output logic              lut_ok,
  output logic              seq_run,
  output logic              busy
);
  logic       want_off;
  logic       doze_q;
  logic       timer_run;
  logic       timer_done;
  lpm_state_e state;

  lpm_mode_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .want_off (want_off),
    .doze_q   (doze_q)
  );

  lpm_frame_timer #(.DELAY_FRAMES(DELAY_FRAMES)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (timer_run),
    .tick  (frame_tick),
    .done  (timer_done)
  );

  lpm_power_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .want_off  (want_off),
    .man_en    (man_pwr_en),
    .done      (timer_done),
    .state     (state),
    .timer_run (timer_run)
  );

  lpm_out_gate #(.DATA_W(DATA_W)) u_gate (
    .state     (state),
    .doze_q    (doze_q),
    .man_en    (man_pwr_en),
    .man_on    (man_pwr_on),
    .vblank_in (vblank_in),
    .src_data  (src_data),
    .src_shift (src_shift),
    .src_line  (src_line),
    .src_frame (src_frame),
    .src_ready (src_ready),
    .pnl_data  (pnl_data),
    .pnl_shift (pnl_shift),
    .pnl_line  (pnl_line),
    .pnl_frame (pnl_frame),
    .pnl_ready (pnl_ready),
    .pnl_pwr   (pnl_pwr),
    .vnd_flag  (vnd_flag),
    .lut_ok    (lut_ok),
    .seq_run   (seq_run),
    .busy      (busy)
  );
endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode_sel,
  input logic              man_pwr_en,
  input logic              frame_tick,
  input logic [DATA_W-1:0] src_data,
  input logic              src_shift,
  input logic [DATA_W-1:0] pnl_data,
  input logic              pnl_shift,
  input logic              pnl_line,
  input logic              pnl_frame,
  input logic              pnl_ready,
  input logic              pnl_pwr,
  input logic              vnd_flag,
  input logic              seq_run,
  input logic              busy
);
  // R5
  stopped_outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_run |-> (pnl_data == '0) && !pnl_shift && !pnl_line && !pnl_frame &&
                 !pnl_ready && !vnd_flag);

  // R5
  stopped_power_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_pwr_en && !seq_run) |-> !pnl_pwr);

  // R4
  power_rise_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_pwr_en && $past(!man_pwr_en) && $rose(pnl_pwr)) |->
      ($past(frame_tick) && $past(busy)));

  // R3
  power_fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!man_pwr_en && $past(!man_pwr_en) && $fell(pnl_pwr)) |->
      ($past(frame_tick) && $past(busy)));

  // R6
  doze_masks_pixels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_sel) == 2'b10) |-> (pnl_data == '0) && !pnl_shift);

  // R7
  normal_passes_pixels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode_sel) == 2'b11) && seq_run) |->
      (pnl_data == src_data) && (pnl_shift == src_shift));
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_lcd_pwr_seq.sv
`timescale 1ns/100ps
module tb_lcd_pwr_seq;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = 2'b00;
  logic          man_pwr_en = 1'b0;
  logic          man_pwr_on = 1'b0;
  logic          frame_tick = 1'b0;
  logic          vblank_in = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic          src_shift = 1'b0;
  logic          src_line = 1'b0;
  logic          src_frame = 1'b0;
  logic          src_ready = 1'b0;
  logic [DW-1:0] pnl_data;
  logic          pnl_shift, pnl_line, pnl_frame, pnl_ready, pnl_pwr;
  logic          vnd_flag, lut_ok, seq_run, busy;

  int  nvec = 0;
  int  nbad = 0;
  bit  fin  = 1'b0;

  always #10 clk = ~clk;

  lcd_pwr_seq #(.DATA_W(DW), .DELAY_FRAMES(1)) dut (.*);

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic tick();
    frame_tick = 1'b1;
    step();
    frame_tick = 1'b0;
  endtask

  // en: signals enabled, dz: doze mask, pw: panel power, bz: busy
  task automatic sweep(input string req, input bit en, input bit dz,
                       input bit pw, input bit bz);
    for (int v = 0; v < 64; v++) begin
      logic [DW+8:0] act, exp;
      src_data  = DW'(v * 37 + 5);
      src_shift = v[0];
      src_line  = v[1];
      src_frame = v[2];
      src_ready = v[3];
      vblank_in = v[5] ^ v[4];
      #0.1;
      exp = {(en && !dz) ? src_data : '0, en && !dz && src_shift,
             en && src_line, en && src_frame, en && src_ready, pw,
             en && vblank_in, en, en, bz};
      act = {pnl_data, pnl_shift, pnl_line, pnl_frame, pnl_ready, pnl_pwr,
             vnd_flag, lut_ok, seq_run, busy};
      nvec++;
      if (act !== exp) begin
        nbad++;
        $display("FAIL %s: pattern %0d actual %h expected %h", req, v, act, exp);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!fin) begin
      nbad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    sweep("R11 reset state", 0, 0, 0, 0);
    mode_sel = 2'b01; step(); step();
    sweep("R2 reserved in power-save", 0, 0, 0, 0);

    // R4 power-up, tick in request cycle is not counted
    mode_sel = 2'b11; frame_tick = 1'b1; step(); frame_tick = 1'b0;
    sweep("R4 release enables signals", 1, 0, 0, 1);
    tick();
    sweep("R4 first tick keeps power off", 1, 0, 0, 1);
    step();
    sweep("R4 between ticks", 1, 0, 0, 1);
    tick();
    sweep("R7 normal pass-through after power-up", 1, 0, 1, 0);
    mode_sel = 2'b01; step(); step();
    sweep("R2 reserved in normal", 1, 0, 1, 0);

    mode_sel = 2'b10; step();
    sweep("R6 doze masks pixels", 1, 1, 1, 0);
    mode_sel = 2'b01; step();
    sweep("R2 reserved in doze", 1, 1, 1, 0);

    // R3 power-down from doze
    mode_sel = 2'b00; frame_tick = 1'b1; step(); frame_tick = 1'b0;
    sweep("R3 pending power-down", 1, 1, 1, 1);
    tick();
    sweep("R3 after first tick", 1, 1, 1, 1);
    tick();
    sweep("R5 settled power-save", 0, 0, 0, 0);

    // R8 abort power-up
    mode_sel = 2'b11; step();
    sweep("R1 normal code starts power-up", 1, 0, 0, 1);
    mode_sel = 2'b00; step();
    sweep("R8 aborted power-up", 0, 0, 0, 0);
    tick(); tick();
    sweep("R8 no late power-up", 0, 0, 0, 0);

    // R8 abort power-down
    mode_sel = 2'b11; step(); tick(); tick();
    sweep("R1 back to normal", 1, 0, 1, 0);
    mode_sel = 2'b00; step(); tick();
    sweep("R3 half-way down", 1, 0, 1, 1);
    mode_sel = 2'b11; step();
    sweep("R8 aborted power-down", 1, 0, 1, 0);
    tick(); tick();
    sweep("R8 power stays on", 1, 0, 1, 0);

    // R9 manual control
    man_pwr_en = 1'b1; man_pwr_on = 1'b1; mode_sel = 2'b00; step();
    sweep("R9 manual down in one clock", 0, 0, 1, 0);
    man_pwr_on = 1'b0;
    sweep("R9 manual power low", 0, 0, 0, 0);
    mode_sel = 2'b10; step();
    sweep("R9 manual up to doze", 1, 1, 0, 0);
    man_pwr_on = 1'b1;
    sweep("R9 manual power high in doze", 1, 1, 1, 0);
    man_pwr_en = 1'b0; man_pwr_on = 1'b0; mode_sel = 2'b11; step();
    sweep("R10 running flag pass", 1, 0, 1, 0);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule